// File: doc/BRIEF.md
# Four-Lane SHA-1 Message Schedule Expander

This block turns one 512-bit message block into the full 80-word SHA-1 message schedule. It emits four consecutive words per clock. A block is written in through a load handshake, and a start pulse then begins the run. Over twenty consecutive cycles the block streams out groups of four words, each tagged with its group number. The first four groups carry the loaded words unchanged. The remaining sixteen groups carry the expanded words, each equal to the one-bit left rotation of the XOR of the words 3, 8, 14 and 16 positions earlier.

A 16-entry circular history holds the most recent words. Per group, a realignment stage picks four windows out of it. The oldest window and the window eight back fall on four-word boundaries. The window fourteen back spans two stored groups. The last lane's nearest term is the first lane's word from the same cycle. That lane is therefore finished by a second XOR with the rotated lane-0 result, which is exact because rotation distributes over XOR. One cycle after the last group, a one-cycle done pulse marks the end of the run. The block then accepts a new load.

Top module: `sha1_wexp4`

## Requirements
- R1: While the internal reset is active and right after it, `ld_ready` is 1, `grp_valid` is 0 and `done` is 0.
- R2: A block is captured on a clock edge where `ld_valid` and `ld_ready` are both 1. Word j (j = 0..15) is taken from bits [511-32j : 480-32j], so word 0 is the most significant 32 bits. The first byte of each word is its most significant byte.
- R3: A `start` pulse while idle with a captured block produces `grp_valid` = 1 on 20 consecutive cycles, starting one cycle after the start edge. `grp_index` runs 0 to 19 in order. In group g, lane k occupies `grp_words` bits [32k+31 : 32k] and holds word 4g+k.
- R4: Groups 0 to 3 carry loaded words 0 to 15 unchanged.
- R5: For i from 16 to 79, word i = rotl1(W[i-3] ^ W[i-8] ^ W[i-14] ^ W[i-16]).
- R6: Lane 3 of every expanded group is correct, even though its i-3 term is the lane-0 word of the same group.
- R7: `done` is high for exactly one cycle, in the cycle after group 19 is presented, and `grp_valid` is 0 in that cycle.
- R8: From the start edge until `done`, `ld_ready` is 0. Load requests in that window are ignored and do not change the words being produced.
- R9: `start` is ignored when no block has been captured since the last run. Each captured block serves exactly one run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_valid | input | 1 | Block load request |
| ld_block | input | 512 | Message block, word 0 in the top 32 bits |
| ld_ready | output | 1 | Block can be loaded (idle) |
| start | input | 1 | Begin emitting the schedule of the captured block |
| grp_valid | output | 1 | A four-word group is presented |
| grp_index | output | 5 | Group number 0..19 |
| grp_words | output | 128 | Lane k in bits [32k+31:32k] |
| done | output | 1 | One-cycle pulse after the final group |

## Verification
The bench builds the block with its default parameters: four lanes, 32-bit words and a 16-word history. Each run therefore wraps the circular history five times and exercises every alignment of the straddling fourteen-back window. The defaults also put the same-cycle dependency on lane 3 of every expanded group. Random blocks are mixed with all-zero, all-one and single-bit blocks. A single set bit shows directly whether a term lands in the wrong lane or is dropped. Ignored starts and loads issued during a run are also driven.

// File: rtl/wexp_pkg.sv
package wexp_pkg;
  localparam int WORD_W   = 32;
  localparam int HIST_N   = 16;
  localparam int ROUNDS_N = 80;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} wexp_state_e;

  function automatic logic [WORD_W-1:0] rotl1(input logic [WORD_W-1:0] x);
    return {x[WORD_W-2:0], x[WORD_W-1]};
  endfunction
endpackage

// File: rtl/wexp_rst_sync.sv
module wexp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/wexp_ctrl.sv
module wexp_ctrl
  import wexp_pkg::*;
#(
  parameter int GROUPS = 20,
  localparam int IDX_W = $clog2(GROUPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_fire,
  input  logic             start,
  output logic             ld_ready,
  output logic             run,
  output logic [IDX_W-1:0] cnt,
  output logic             done
);
  wexp_state_e      state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             loaded_q, loaded_d;
  logic             done_q, done_d;
  logic             cnt_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    loaded_d = loaded_q;
    done_d   = 1'b0;
    cnt_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ld_fire) loaded_d = 1'b1;
        if (start && loaded_q) begin
          state_d  = ST_RUN;
          cnt_d    = '0;
          cnt_en   = 1'b1;
          loaded_d = 1'b0;
        end
      end
      ST_RUN: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + IDX_W'(1);
        if (cnt_q == IDX_W'(GROUPS - 1)) state_d = ST_FIN;
      end
      ST_FIN: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      loaded_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      loaded_q <= loaded_d;
      done_q   <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign ld_ready = (state_q == ST_IDLE);
  assign run      = (state_q == ST_RUN);
  assign cnt      = cnt_q;
  assign done     = done_q;
endmodule

// File: rtl/wexp_window.sv
module wexp_window
  import wexp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = HIST_N,
  localparam int SL   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][WORD_W-1:0] hist,
  input  logic [SL-1:0]                base,
  output logic [LANES-1:0][WORD_W-1:0] t16,
  output logic [LANES-1:0][WORD_W-1:0] t14,
  output logic [LANES-1:0][WORD_W-1:0] t8,
  output logic [LANES-1:0][WORD_W-1:0] t3
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int O16 = (k + DEPTH - 16) % DEPTH;
    localparam int O14 = (k + DEPTH - 14) % DEPTH;
    localparam int O8  = (k + DEPTH - 8)  % DEPTH;
    localparam int O3  = (k + DEPTH - 3)  % DEPTH;
    logic [SL-1:0] s16, s14, s8, s3;
    assign s16    = base + SL'(O16);
    assign s14    = base + SL'(O14);
    assign s8     = base + SL'(O8);
    assign s3     = base + SL'(O3);
    assign t16[k] = hist[s16];
    assign t14[k] = hist[s14];
    assign t8[k]  = hist[s8];
    assign t3[k]  = hist[s3];
  end
endmodule

// File: rtl/wexp_lanes.sv
module wexp_lanes
  import wexp_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0][WORD_W-1:0] t16,
  input  logic [LANES-1:0][WORD_W-1:0] t14,
  input  logic [LANES-1:0][WORD_W-1:0] t8,
  input  logic [LANES-1:0][WORD_W-1:0] t3,
  output logic [LANES-1:0][WORD_W-1:0] words
);
  logic [WORD_W-1:0] part [LANES];
  logic [WORD_W-1:0] res  [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k < 3) begin : g_direct
      assign part[k] = t16[k] ^ t14[k] ^ t8[k] ^ t3[k];
      assign res[k]  = rotl1(part[k]);
    end else begin : g_fixup
      assign part[k] = t16[k] ^ t14[k] ^ t8[k];
      assign res[k]  = rotl1(part[k]) ^ rotl1(res[k-3]);
    end
    assign words[k] = res[k];
  end
endmodule

// File: rtl/sha1_wexp4.sv
module sha1_wexp4
  import wexp_pkg::*;
#(
  parameter int LANES    = 4,
  localparam int BLK_W   = HIST_N * WORD_W,
  localparam int GROUPS  = ROUNDS_N / LANES,
  localparam int IDX_W   = $clog2(GROUPS),
  localparam int SEED_G  = HIST_N / LANES,
  localparam int SL      = $clog2(HIST_N),
  localparam int GRP_W   = LANES * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [BLK_W-1:0] ld_block,
  output logic             ld_ready,
  input  logic             start,
  output logic             grp_valid,
  output logic [IDX_W-1:0] grp_index,
  output logic [GRP_W-1:0] grp_words,
  output logic             done
);
  logic rst_n_i;
  logic ld_fire, run;
  logic [IDX_W-1:0] cnt;
  logic [SL-1:0]    base;

  logic [HIST_N-1:0][WORD_W-1:0] hist_q, hist_d;
  logic                          hist_en;
  logic [LANES-1:0][WORD_W-1:0]  t16, t14, t8, t3, new_w, seed_w;

  logic             vld_q, vld_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [GRP_W-1:0] out_q, out_d;

  wexp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  wexp_ctrl #(.GROUPS(GROUPS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .ld_fire  (ld_fire),
    .start    (start),
    .ld_ready (ld_ready),
    .run      (run),
    .cnt      (cnt),
    .done     (done)
  );

  assign ld_fire = ld_valid && ld_ready;
  assign base    = SL'(cnt * LANES);

  wexp_window #(.LANES(LANES), .DEPTH(HIST_N)) u_win (
    .hist (hist_q),
    .base (base),
    .t16  (t16),
    .t14  (t14),
    .t8   (t8),
    .t3   (t3)
  );

  wexp_lanes #(.LANES(LANES)) u_lanes (
    .t16   (t16),
    .t14   (t14),
    .t8    (t8),
    .t3    (t3),
    .words (new_w)
  );

  // oldest window equals the loaded words while the seed groups stream out
  assign seed_w = t16;

  always_comb begin
    hist_d  = hist_q;
    hist_en = 1'b0;
    if (ld_fire) begin
      hist_en = 1'b1;
      for (int j = 0; j < HIST_N; j++)
        hist_d[j] = ld_block[BLK_W-1-WORD_W*j -: WORD_W];
    end else if (run && (cnt >= IDX_W'(SEED_G))) begin
      hist_en = 1'b1;
      for (int k = 0; k < LANES; k++)
        hist_d[base + SL'(k)] = new_w[k];
    end
  end

  always_comb begin
    vld_d = run;
    idx_d = cnt;
    out_d = (cnt < IDX_W'(SEED_G)) ? GRP_W'(seed_w) : GRP_W'(new_w);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      hist_q <= '0;
      vld_q  <= 1'b0;
      idx_q  <= '0;
      out_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (hist_en) hist_q <= hist_d;
      if (run) begin
        idx_q <= idx_d;
        out_q <= out_d;
      end
    end
  end

  assign grp_valid = vld_q;
  assign grp_index = idx_q;
  assign grp_words = out_q;
endmodule

// File: rtl/sha1_wexp4_chk.sv
module sha1_wexp4_chk #(
  parameter int IDX_W  = 5,
  parameter int GROUPS = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_ready,
  input logic             grp_valid,
  input logic [IDX_W-1:0] grp_index,
  input logic             done
);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !grp_valid);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_index == IDX_W'(GROUPS - 1)) |=> done);

  // R3
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_index != IDX_W'(GROUPS - 1)) |=>
      (grp_valid && grp_index == $past(grp_index) + IDX_W'(1)));

  // R3
  first_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_valid) |-> grp_index == '0);

  // R8
  busy_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> !ld_ready);
endmodule

bind sha1_wexp4 sha1_wexp4_chk #(.IDX_W(IDX_W), .GROUPS(GROUPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_i),
  .ld_ready  (ld_ready),
  .grp_valid (grp_valid),
  .grp_index (grp_index),
  .done      (done)
);

// File: tb/sim_sha1_wexp4.sv
`timescale 1ns/1ps
module sim_sha1_wexp4;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_valid = 1'b0;
  logic [511:0] ld_block = '0;
  logic         ld_ready;
  logic         start = 1'b0;
  logic         grp_valid;
  logic [4:0]   grp_index;
  logic [127:0] grp_words;
  logic         done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] ref_w [80];

  always #5 clk = ~clk;

  sha1_wexp4 u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_block(ld_block),
    .ld_ready(ld_ready), .start(start), .grp_valid(grp_valid),
    .grp_index(grp_index), .grp_words(grp_words), .done(done)
  );

  function automatic logic [31:0] rl1(input logic [31:0] x);
    return {x[30:0], x[31]};
  endfunction

  task automatic build_ref(input logic [511:0] blk);
    for (int j = 0; j < 16; j++) ref_w[j] = blk[511-32*j -: 32];
    for (int i = 16; i < 80; i++)
      ref_w[i] = rl1(ref_w[i-3] ^ ref_w[i-8] ^ ref_w[i-14] ^ ref_w[i-16]);
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [511:0] blk);
    @(negedge clk);
    chk("R2 ld_ready before load", 128'(ld_ready), 128'(1));
    ld_valid = 1'b1;
    ld_block = blk;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  // runs one block; when disturb is set, a foreign load is requested during the run
  task automatic run_block(input logic [511:0] blk, input bit disturb);
    build_ref(blk);
    load(blk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 no group at start edge", 128'(grp_valid), 128'(0));
    chk("R8 ld_ready low after start", 128'(ld_ready), 128'(0));
    for (int g = 0; g < 20; g++) begin
      if (disturb) begin
        ld_valid = (g % 3 == 0);
        ld_block = ~blk;
      end
      @(negedge clk);
      chk("R3 grp_valid", 128'(grp_valid), 128'(1));
      chk("R3 grp_index", 128'(grp_index), 128'(g));
      for (int k = 0; k < 4; k++) begin
        if (g < 4)       chk("R4 seed word", 128'(grp_words[32*k +: 32]), 128'(ref_w[4*g+k]));
        else if (k == 3) chk("R6 lane3 fixup", 128'(grp_words[32*k +: 32]), 128'(ref_w[4*g+k]));
        else             chk(disturb ? "R8 word under load attempt" : "R5 expanded word",
                             128'(grp_words[32*k +: 32]), 128'(ref_w[4*g+k]));
      end
    end
    ld_valid = 1'b0;
    @(negedge clk);
    chk("R7 done pulse", 128'(done), 128'(1));
    chk("R7 grp_valid low with done", 128'(grp_valid), 128'(0));
    @(negedge clk);
    chk("R7 done single cycle", 128'(done), 128'(0));
    chk("R8 ld_ready back", 128'(ld_ready), 128'(1));
  endtask

  task automatic expect_no_run(input string req);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(req, 128'(grp_valid), 128'(0));
    end
  endtask

  initial begin
    logic [511:0] blk;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 ld_ready in reset", 128'(ld_ready), 128'(1));
    chk("R1 grp_valid in reset", 128'(grp_valid), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done after reset", 128'(done), 128'(0));
    chk("R1 grp_valid after reset", 128'(grp_valid), 128'(0));

    // R9: start with nothing loaded
    expect_no_run("R9 start without block");

    // directed corner cases
    run_block('0, 1'b0);
    run_block({512{1'b1}}, 1'b0);
    run_block(512'(1) << 511, 1'b0);
    run_block(512'(1), 1'b0);
    // R2 byte order: distinct bytes in ascending order
    for (int b = 0; b < 64; b++) blk[511-8*b -: 8] = 8'(b);
    run_block(blk, 1'b0);

    // R9: block consumed by the previous run
    expect_no_run("R9 start after block consumed");

    // random blocks, some with load attempts mid-run (R8)
    for (int n = 0; n < 8; n++) begin
      for (int j = 0; j < 16; j++) blk[32*j +: 32] = $urandom;
      run_block(blk, n[0]);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule